// File: doc/BRIEF.md
# Protected Memory Window Lock Controller

This block combines one configuration register with a gate that sits on a memory access path. Firmware opens the feature by writing the probe command to the register, which then reads back a "present" code. It installs its system-management handler into a fixed 128 KiB memory window, and then writes the seal command. Once sealed, the window can only be reached by accesses made while the system-management mode input is high. Other accesses that hit the window read as all ones, and their writes never reach memory. The register itself ignores every write until the next reset.

The configuration side is a plain byte interface: a write strobe, an 8-bit offset and a write byte, with read data returned combinationally for the offset presented. The memory side watches each request's address, direction and mode flag. It forwards or substitutes the read data coming back from RAM, and it raises or withholds the RAM write enable. The configuration transaction layer, the RAM and the source of the mode signal all live outside this block.

Top module: `smram_lock_ctrl`

## Requirements
- R1: After reset the register at offset 0x9c reads 0x00, and non-mode accesses to the window reach memory unchanged.
- R2: In the reset state, writing 0xff to offset 0x9c makes the register read 0x01 from the next cycle on.
- R3: Before the probe, a write of 0x02 leaves the register at 0x00. In any unsealed state, writes of values other than 0xff and 0x02 leave the register value unchanged.
- R4: With the register reading 0x01, writing 0x02 seals the window, and the register then reads 0x02.
- R5: Once sealed, the register keeps reading 0x02 whatever is written to it, until reset returns it to 0x00.
- R6: Writes to any offset other than 0x9c change nothing, and reads of any other offset return 0x00.
- R7: While unsealed, a non-mode read of the window returns the memory data, and a non-mode write to the window asserts the memory write enable.
- R8: While sealed, a non-mode read that hits the window returns 0xff in every byte lane.
- R9: While sealed, a non-mode write that hits the window keeps the memory write enable low.
- R10: A request made with the mode input high always passes through: memory read data is returned and a write asserts the write enable, sealed or not.
- R11: The window is half-open. Addresses 0x30000 through 0x4ffff hit it, while 0x2ffff and 0x50000 do not.
- R12: Requests outside the window are never altered: the read data equals the memory data, and the write enable follows the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset for reads and writes |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for cfg_addr |
| req_valid | input | 1 | Memory request present this cycle |
| req_write | input | 1 | Request is a write (1) or read (0) |
| req_smm | input | 1 | Request issued in system-management mode |
| req_addr | input | 32 | Request byte address |
| mem_rdata | input | 32 | Read data returned by the RAM |
| req_rdata | output | 32 | Read data handed back to the requester |
| mem_we | output | 1 | Write enable toward the RAM |

## Verification
The bench targets the ordering of the protocol. A design that accepted the seal command without a prior probe would read 0x02 too early. One that kept decoding after sealing would drop back to 0x01 on a later probe write. It then tests the two window edges on each side. An inclusive upper bound or an exclusive lower bound would mask reads at 0x50000 or let writes through at 0x30000. It also runs mode-high requests against the sealed window, because gating that ignores the mode flag would lock out the handler itself. Finally it checks that a later reset unfreezes the register, since a design whose sticky state survived reset would stay sealed.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int unsigned CFG_AW = 8;

    localparam logic [7:0] CFG_OFFSET_DEF = 8'h9c;
    localparam logic [31:0] WIN_BASE_DEF  = 32'h0003_0000;
    localparam logic [31:0] WIN_SIZE_DEF  = 32'h0002_0000;

    localparam logic [7:0] CMD_PROBE = 8'hff;
    localparam logic [7:0] CMD_SEAL  = 8'h02;

    localparam logic [7:0] CODE_CLOSED = 8'h00;
    localparam logic [7:0] CODE_ARMED  = 8'h01;
    localparam logic [7:0] CODE_SEALED = 8'h02;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_SEALED = 2'd2
    } lk_state_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic smm;
        logic hit;
    } req_view_t;

    function automatic logic [7:0] state_code(lk_state_e s);
        case (s)
            LK_ARMED:  return CODE_ARMED;
            LK_SEALED: return CODE_SEALED;
            default:   return CODE_CLOSED;
        endcase
    endfunction

    function automatic lk_state_e next_state(lk_state_e s, logic [7:0] cmd);
        case (s)
            LK_CLOSED: return (cmd == CMD_PROBE) ? LK_ARMED : LK_CLOSED;
            LK_ARMED:  return (cmd == CMD_SEAL) ? LK_SEALED : LK_ARMED;
            default:   return LK_SEALED;
        endcase
    endfunction

    function automatic bit pow2_aligned(logic [63:0] base, logic [63:0] size);
        return (size != 64'd0) && ((size & (size - 64'd1)) == 64'd0)
            && ((base & (size - 64'd1)) == 64'd0);
    endfunction

endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output lk_state_e  state,
    output logic [7:0] code
);

    lk_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_CLOSED;
        end else if (wr_en) begin
            state_q <= next_state(state_q, wr_byte);
        end
    end

    assign state = state_q;
    assign code  = state_code(state_q);

endmodule

// File: rtl/smram_window_match.sv
module smram_window_match #(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam bit ALIGNED = smram_pkg::pow2_aligned(64'(WIN_BASE), 64'(WIN_SIZE));

    generate
        if (ALIGNED) begin : g_mask
            localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
            localparam logic [ADDR_W-1:0] MASK = ~(WIN_SIZE - ONE);
            assign hit = ((addr & MASK) == WIN_BASE);
        end else begin : g_range
            localparam logic [ADDR_W:0] LO = {1'b0, WIN_BASE};
            localparam logic [ADDR_W:0] HI = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
            logic [ADDR_W:0] addr_x;
            assign addr_x = {1'b0, addr};
            assign hit = (addr_x >= LO) && (addr_x < HI);
        end
    endgenerate

endmodule

// File: rtl/smram_mem_gate.sv
module smram_mem_gate
    import smram_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  req_view_t         rq,
    input  logic              sealed,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_we
);

    localparam int unsigned LANES = DATA_W / 8;

    logic blocked;
    logic mask_rd;

    assign blocked = rq.valid && rq.hit && sealed && !rq.smm;
    assign mask_rd = blocked && !rq.write;
    assign mem_we  = rq.valid && rq.write && !blocked;

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign req_rdata[b*8 +: 8] = mask_rd ? 8'hff : mem_rdata[b*8 +: 8];
        end
    endgenerate

endmodule

// File: rtl/smram_lock_ctrl.sv
module smram_lock_ctrl
    import smram_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [CFG_AW-1:0] CFG_OFFSET = CFG_OFFSET_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE   = WIN_BASE_DEF,
    parameter logic [ADDR_W-1:0] WIN_SIZE   = WIN_SIZE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_we
);

    logic      cfg_sel;
    lk_state_e lk_state;
    logic [7:0] reg_code;
    logic      win_hit;
    req_view_t rq;

    assign cfg_sel = (cfg_addr == CFG_OFFSET);

    smram_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr && cfg_sel),
        .wr_byte (cfg_wdata),
        .state   (lk_state),
        .code    (reg_code)
    );

    assign cfg_rdata = cfg_sel ? reg_code : 8'h00;

    smram_window_match #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_win (
        .addr (req_addr),
        .hit  (win_hit)
    );

    assign rq.valid = req_valid;
    assign rq.write = req_write;
    assign rq.smm   = req_smm;
    assign rq.hit   = win_hit;

    smram_mem_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .rq        (rq),
        .sealed    (lk_state == LK_SEALED),
        .mem_rdata (mem_rdata),
        .req_rdata (req_rdata),
        .mem_we    (mem_we)
    );

endmodule

// File: rtl/smram_lock_ctrl_chk.sv
module smram_lock_ctrl_chk #(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [7:0]        CFG_OFFSET = 8'h9c,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0002_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_smm,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] req_rdata,
    input logic              mem_we,
    input logic [7:0]        reg_code
);

    logic [ADDR_W:0] a_x;
    logic [ADDR_W:0] lo_x;
    logic [ADDR_W:0] hi_x;
    logic            in_win;
    logic            sealed;

    assign a_x    = {1'b0, req_addr};
    assign lo_x   = {1'b0, WIN_BASE};
    assign hi_x   = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
    assign in_win = (a_x >= lo_x) && (a_x < hi_x);
    assign sealed = (reg_code == 8'h02);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reg_code == 8'h00);

    assert_seal_needs_probe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sealed) |-> $past(cfg_wr && cfg_addr == CFG_OFFSET
                                && cfg_wdata == 8'h02 && reg_code == 8'h01));

    assert_seal_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        sealed |=> sealed);

    assert_open_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (!sealed && req_valid) |-> (mem_we == req_write && req_rdata == mem_rdata));

    assert_read_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (sealed && req_valid && !req_write && !req_smm && in_win) |-> (&req_rdata));

    assert_write_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (sealed && req_valid && req_write && !req_smm && in_win) |-> !mem_we);

    assert_mode_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_smm) |-> (mem_we == req_write && req_rdata == mem_rdata));

    assert_outside_clean_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_win) |-> (mem_we == req_write && req_rdata == mem_rdata));

endmodule

bind smram_lock_ctrl smram_lock_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CFG_OFFSET (CFG_OFFSET),
    .WIN_BASE   (WIN_BASE),
    .WIN_SIZE   (WIN_SIZE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_smm   (req_smm),
    .req_addr  (req_addr),
    .mem_rdata (mem_rdata),
    .req_rdata (req_rdata),
    .mem_we    (mem_we),
    .reg_code  (reg_code)
);

// File: tb/smram_lock_ctrl_tb.sv
module smram_lock_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic [31:0] mem_rdata = 32'h5a3c_1e87;
    logic [31:0] req_rdata;
    logic        mem_we;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] MEMPAT = 32'h5a3c_1e87;

    always #2 clk = ~clk;

    smram_lock_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_smm   (req_smm),
        .req_addr  (req_addr),
        .mem_rdata (mem_rdata),
        .req_rdata (req_rdata),
        .mem_we    (mem_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_addr  = off;
        cfg_wdata = val;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic cfg_expect(input logic [7:0] off, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = off;
        #1;
        chk(tag, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic mem_access(input logic [31:0] a, input logic wr, input logic smm,
                              input logic exp_we, input logic [31:0] exp_rd, input string tag);
        @(negedge clk);
        req_addr  = a;
        req_write = wr;
        req_smm   = smm;
        req_valid = 1'b1;
        #1;
        chk({tag, " we"}, {31'h0, mem_we}, {31'h0, exp_we});
        if (!wr) chk({tag, " rdata"}, req_rdata, exp_rd);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset_state();
        do_reset();
        cfg_expect(8'h9c, 8'h00, "R1 reset readback");
        mem_access(32'h0003_0000, 1'b1, 1'b0, 1'b1, 32'h0, "R1 open write");
        mem_access(32'h0003_0000, 1'b0, 1'b0, 1'b0, MEMPAT, "R1 open read");
    endtask

    // R3, R6: ignored writes before probe
    task automatic t_premature();
        cfg_write(8'h9c, 8'h02);
        cfg_expect(8'h9c, 8'h00, "R3 seal before probe");
        cfg_write(8'h9c, 8'h55);
        cfg_expect(8'h9c, 8'h00, "R3 other value closed");
        cfg_write(8'h9d, 8'hff);
        cfg_expect(8'h9c, 8'h00, "R6 probe wrong offset");
        cfg_expect(8'h9d, 8'h00, "R6 other offset read");
    endtask

    // R2, R3, R7: probe and open-window access
    task automatic t_probe();
        cfg_write(8'h9c, 8'hff);
        cfg_expect(8'h9c, 8'h01, "R2 probe readback");
        cfg_write(8'h9c, 8'h33);
        cfg_expect(8'h9c, 8'h01, "R3 other value armed");
        cfg_write(8'h9c, 8'hff);
        cfg_expect(8'h9c, 8'h01, "R3 repeat probe armed");
        cfg_write(8'h1c, 8'h02);
        cfg_expect(8'h9c, 8'h01, "R6 seal wrong offset");
        mem_access(32'h0003_1000, 1'b1, 1'b0, 1'b1, 32'h0, "R7 armed write");
        mem_access(32'h0004_fffc, 1'b0, 1'b0, 1'b0, MEMPAT, "R7 armed read");
    endtask

    // R4: seal
    task automatic t_seal();
        cfg_write(8'h9c, 8'h02);
        cfg_expect(8'h9c, 8'h02, "R4 sealed readback");
    endtask

    // R8-R12: sealed gating
    task automatic t_sealed_access();
        mem_access(32'h0003_0000, 1'b0, 1'b0, 1'b0, 32'hffff_ffff, "R8 low edge read");
        mem_access(32'h0004_ffff, 1'b0, 1'b0, 1'b0, 32'hffff_ffff, "R8 high edge read");
        mem_access(32'h0003_0000, 1'b1, 1'b0, 1'b0, 32'h0, "R9 low edge write");
        mem_access(32'h0004_ffff, 1'b1, 1'b0, 1'b0, 32'h0, "R9 high edge write");
        mem_access(32'h0004_0000, 1'b0, 1'b1, 1'b0, MEMPAT, "R10 mode read");
        mem_access(32'h0004_0000, 1'b1, 1'b1, 1'b1, 32'h0, "R10 mode write");
        mem_access(32'h0002_ffff, 1'b0, 1'b0, 1'b0, MEMPAT, "R11 below read");
        mem_access(32'h0005_0000, 1'b0, 1'b0, 1'b0, MEMPAT, "R11 above read");
        mem_access(32'h0005_0000, 1'b1, 1'b0, 1'b1, 32'h0, "R11 above write");
        mem_access(32'h0002_ffff, 1'b1, 1'b0, 1'b1, 32'h0, "R12 below write");
        mem_access(32'h8003_0000, 1'b0, 1'b0, 1'b0, MEMPAT, "R12 far read");
    endtask

    // R5: frozen until reset
    task automatic t_frozen();
        cfg_write(8'h9c, 8'hff);
        cfg_expect(8'h9c, 8'h02, "R5 probe after seal");
        cfg_write(8'h9c, 8'h00);
        cfg_expect(8'h9c, 8'h02, "R5 clear after seal");
        do_reset();
        cfg_expect(8'h9c, 8'h00, "R5 reset unfreezes");
        mem_access(32'h0003_8000, 1'b0, 1'b0, 1'b0, MEMPAT, "R5 reopened read");
    endtask

    initial begin
        t_reset_state();
        t_premature();
        t_probe();
        t_seal();
        t_sealed_access();
        t_frozen();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule